// File: doc/BRIEF.md
# Precision-Time Pin Waveform Generator

This block drives four timing output pins from a precision time-of-day source that sits outside it. The time source presents a nanosecond tick strobe with a step size and a strobe that marks each roll-over of the seconds count. Each pin has its own bank of three registers: a low duration, a high duration and a configuration word. The pin is chosen by an index on a shared write port.

A pin in free-running clock mode alternates between a low phase and a high phase, each measured in nanoseconds of the time base. The clock period is the sum of the two durations. Its phase starts when the configuration is written, because no absolute start time can be programmed. In seconds-aligned mode the pin waits for each seconds roll-over. It then holds low for the low duration and raises one pulse of the high duration. The result is a once-per-second pulse whose phase offset is the low duration. The usual pulse width is 1000 ns.

A free-running setup whose durations fall outside the legal half-period range is refused. The refusal sets a sticky error flag for that pin.

Top module: `ptp_pin_wavegen`

## Requirements
- R1: After reset every pin output is low and every error flag is clear, and every pin is idle.
- R2: A write reaches only the pin named by `wr_pin`. `wr_sel` picks the register: 0 is the low duration, 1 is the high duration, 2 is the configuration, and 3 writes nothing.
- R3: Configuration bits [1:0] select the action: 1 is CLOCK, and 0, 2 and 3 are IDLE. Writing IDLE drives the pin low from the next cycle, and the pin then holds low.
- R4: A CLOCK write with bit 2 clear restarts the pin in its low phase with a cleared counter. The pin then alternates between a low phase of low-duration ns and a high phase of high-duration ns.
- R5: A phase ends on the tick at which the accumulated count reaches or passes the phase duration. Any excess carries into the count of the next phase.
- R6: The phase counters advance by `ns_step` ns only on cycles with `ns_tick` high. With no tick, no roll-over and no configuration write, the pin holds its level.
- R7: A duration written while a pin runs does not change the phase in progress. It takes effect the next time a phase of that kind begins.
- R8: A CLOCK write with bit 2 set (seconds-aligned mode) holds the pin low until a roll-over. After each roll-over the pin is low for low-duration ns, then high for high-duration ns, then low until the next roll-over.
- R9: In seconds-aligned mode every roll-over restarts the low phase with a cleared counter, even while a pulse is high.
- R10: A free-running CLOCK write is refused when either duration is 6 or less, or greater than 0x3FFFFFFF. A refused write sets that pin's error flag and leaves the pin idle. The flag clears only on reset. The range check does not apply in seconds-aligned mode.
- R11: Roll-over strobes have no effect on a free-running clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_pin | input | 2 | Target pin index |
| wr_sel | input | 2 | Register select: 0 low duration, 1 high duration, 2 configuration |
| wr_data | input | 32 | Write data |
| ns_tick | input | 1 | Time-base advance strobe |
| ns_step | input | 8 | Nanoseconds added per tick |
| sec_roll | input | 1 | Seconds roll-over strobe |
| pin_out | output | 4 | Pin waveforms, one bit per pin |
| cfg_err | output | 4 | Sticky range-error flags, one bit per pin |

## Verification
The bench builds the block with its defaults: four pins, 32-bit durations and an 8-bit step. The 32-bit durations let both edges of the legal range, 0x3FFFFFFF and 0x40000000, be written and checked. The bench uses steps of 8 and 4 ns, so durations of a few tens of ns turn into runs of a handful of cycles. That makes exact phase lengths, carried remainders and boundary-timed duration updates observable cycle by cycle. A 1000 ns pulse becomes a 125-cycle run, so full seconds-aligned pulses and mid-pulse re-arming fit in a short run.

// File: rtl/ptp_wave_pkg.sv
package ptp_wave_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_WAIT = 2'd3
    } phase_e;

    // Register select codes on the write port
    localparam logic [1:0] SEL_LOW  = 2'd0;
    localparam logic [1:0] SEL_HIGH = 2'd1;
    localparam logic [1:0] SEL_CFG  = 2'd2;

    // Configuration word layout
    localparam logic [1:0] ACT_CLOCK = 2'd1;
    localparam int         SYNC_BIT  = 2;

    typedef struct packed {
        logic run;
        logic sync;
    } mode_t;

endpackage

// File: rtl/ptp_wr_decode.sv
module ptp_wr_decode
    import ptp_wave_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int PIN_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PIN_W-1:0]    wr_pin,
    input  logic [1:0]          wr_sel,
    output logic [NUM_PINS-1:0] low_we,
    output logic [NUM_PINS-1:0] high_we,
    output logic [NUM_PINS-1:0] cfg_we
);

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            low_we[i]  = wr_en && (wr_pin == PIN_W'(i)) && (wr_sel == SEL_LOW);
            high_we[i] = wr_en && (wr_pin == PIN_W'(i)) && (wr_sel == SEL_HIGH);
            cfg_we[i]  = wr_en && (wr_pin == PIN_W'(i)) && (wr_sel == SEL_CFG);
        end
    end

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_we, high_we, cfg_we}));

    // R2
    no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> ({low_we, high_we, cfg_we} == '0));

endmodule

// File: rtl/ptp_pin_regs.sv
module ptp_pin_regs
    import ptp_wave_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          DUR_W    = 32,
    parameter int unsigned MIN_HALF = 6,
    parameter int unsigned MAX_HALF = 32'h3FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_we,
    input  logic              high_we,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DUR_W-1:0]  low_dur,
    output logic [DUR_W-1:0]  high_dur,
    output logic              start,
    output mode_t             start_mode,
    output logic              err_flag
);

    localparam logic [DUR_W-1:0] LIM_LO = DUR_W'(MIN_HALF);
    localparam logic [DUR_W-1:0] LIM_HI = DUR_W'(MAX_HALF);

    typedef struct packed {
        logic [DUR_W-1:0] low;
        logic [DUR_W-1:0] high;
        logic             err;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  is_clock, want_sync, out_of_range, refuse;

    always_comb begin
        bank_d       = bank_q;
        is_clock     = (wr_data[1:0] == ACT_CLOCK);
        want_sync    = wr_data[SYNC_BIT];
        out_of_range = (bank_q.low  <= LIM_LO) || (bank_q.low  > LIM_HI) ||
                       (bank_q.high <= LIM_LO) || (bank_q.high > LIM_HI);
        refuse       = cfg_we && is_clock && !want_sync && out_of_range;

        if (low_we)  bank_d.low  = wr_data[DUR_W-1:0];
        if (high_we) bank_d.high = wr_data[DUR_W-1:0];
        if (refuse)  bank_d.err  = 1'b1;

        start           = cfg_we;
        start_mode.run  = is_clock && !refuse;
        start_mode.sync = want_sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign low_dur  = bank_q.low;
    assign high_dur = bank_q.high;
    assign err_flag = bank_q.err;

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R10
    short_low_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wr_data[1:0] == ACT_CLOCK && !wr_data[SYNC_BIT] && low_dur <= LIM_LO)
        |=> err_flag);

endmodule

// File: rtl/ptp_pin_fsm.sv
module ptp_pin_fsm
    import ptp_wave_pkg::*;
#(
    parameter int DUR_W = 32,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  mode_t            start_mode,
    input  logic [DUR_W-1:0] low_dur,
    input  logic [DUR_W-1:0] high_dur,
    input  logic             tick,
    input  logic [INC_W-1:0] tick_inc,
    input  logic             sec_roll,
    output logic             pin_out
);

    localparam int CW = DUR_W + 1;

    typedef struct packed {
        phase_e           phase;
        logic [CW-1:0]    cnt;
        logic [DUR_W-1:0] cur_low;
        logic [DUR_W-1:0] cur_high;
        logic             sync;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic [CW-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = st_q.cnt + CW'(tick_inc);
        if (start) begin
            st_d.cnt     = '0;
            st_d.sync    = start_mode.sync;
            st_d.cur_low = low_dur;
            if (!start_mode.run)     st_d.phase = PH_IDLE;
            else if (start_mode.sync) st_d.phase = PH_WAIT;
            else                      st_d.phase = PH_LOW;
        end else if (sec_roll && st_q.sync && st_q.phase != PH_IDLE) begin
            st_d.phase   = PH_LOW;
            st_d.cnt     = '0;
            st_d.cur_low = low_dur;
        end else if (tick) begin
            unique case (st_q.phase)
                PH_LOW: begin
                    if (sum >= {1'b0, st_q.cur_low}) begin
                        st_d.phase    = PH_HIGH;
                        st_d.cnt      = sum - {1'b0, st_q.cur_low};
                        st_d.cur_high = high_dur;
                    end else begin
                        st_d.cnt = sum;
                    end
                end
                PH_HIGH: begin
                    if (sum >= {1'b0, st_q.cur_high}) begin
                        if (st_q.sync) begin
                            st_d.phase = PH_WAIT;
                            st_d.cnt   = '0;
                        end else begin
                            st_d.phase   = PH_LOW;
                            st_d.cnt     = sum - {1'b0, st_q.cur_high};
                            st_d.cur_low = low_dur;
                        end
                    end else begin
                        st_d.cnt = sum;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign pin_out = (st_q.phase == PH_HIGH);

    // R4
    restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !pin_out);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !start) |=> !pin_out);

    // R6
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start && !sec_roll) |=> $stable(pin_out));

    // R9
    roll_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_roll && st_q.sync && st_q.phase != PH_IDLE && !start) |=> !pin_out);

    // R11
    roll_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_roll && !tick && !start && !st_q.sync) |=> $stable(pin_out));

endmodule

// File: rtl/ptp_pin_wavegen.sv
module ptp_pin_wavegen
    import ptp_wave_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int DATA_W   = 32,
    parameter int DUR_W    = 32,
    parameter int INC_W    = 8,
    parameter int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PIN_W-1:0]    wr_pin,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                ns_tick,
    input  logic [INC_W-1:0]    ns_step,
    input  logic                sec_roll,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] cfg_err
);

    logic [NUM_PINS-1:0] low_we, high_we, cfg_we;

    ptp_wr_decode #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_pin  (wr_pin),
        .wr_sel  (wr_sel),
        .low_we  (low_we),
        .high_we (high_we),
        .cfg_we  (cfg_we)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic [DUR_W-1:0] low_dur, high_dur;
        logic             start;
        mode_t            start_mode;

        ptp_pin_regs #(.DATA_W(DATA_W), .DUR_W(DUR_W)) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .low_we     (low_we[g]),
            .high_we    (high_we[g]),
            .cfg_we     (cfg_we[g]),
            .wr_data    (wr_data),
            .low_dur    (low_dur),
            .high_dur   (high_dur),
            .start      (start),
            .start_mode (start_mode),
            .err_flag   (cfg_err[g])
        );

        ptp_pin_fsm #(.DUR_W(DUR_W), .INC_W(INC_W)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (start),
            .start_mode (start_mode),
            .low_dur    (low_dur),
            .high_dur   (high_dur),
            .tick       (ns_tick),
            .tick_inc   (ns_step),
            .sec_roll   (sec_roll),
            .pin_out    (pin_out[g])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && cfg_err == '0));

endmodule

// File: tb/tb_ptp_pin_wavegen.sv
`timescale 1ns/1ps
module tb_ptp_pin_wavegen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_pin = '0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        ns_tick = 1'b0;
    logic [7:0]  ns_step = 8'd8;
    logic        sec_roll = 1'b0;
    logic [3:0]  pin_out;
    logic [3:0]  cfg_err;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ptp_pin_wavegen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pin(wr_pin),
        .wr_sel(wr_sel), .wr_data(wr_data), .ns_tick(ns_tick),
        .ns_step(ns_step), .sec_roll(sec_roll),
        .pin_out(pin_out), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int p, input int sel, input logic [31:0] d);
        wr_en = 1'b1; wr_pin = 2'(p); wr_sel = 2'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic roll();
        sec_roll = 1'b1;
        @(negedge clk);
        sec_roll = 1'b0;
    endtask

    task automatic run_len(input int p, input logic lvl, input int cap, output int n);
        n = 0;
        while (pin_out[p] == lvl && n < cap) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_level(input int p, input logic lvl);
        for (int k = 0; k < 2000 && pin_out[p] != lvl; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pins low", int'(pin_out), 0);
        chk("R1 errors clear", int'(cfg_err), 0);
    endtask

    task automatic t_select();
        int n;
        wr(0, 0, 40); wr(0, 1, 24);
        wr(0, 3, 1);
        run_len(0, 1'b0, 20, n);
        chk("R2 select 3 writes nothing", n, 20);
        chk("R2 no error from select 3", int'(cfg_err), 0);
        wr(1, 0, 40); wr(1, 1, 24); wr(1, 2, 1);
        wr(0, 2, 0);
        wait_level(1, 1'b1);
        run_len(1, 1'b1, 100, n);
        chk("R2 other pin high", n, 3);
        run_len(1, 1'b0, 100, n);
        chk("R2 other pin low", n, 5);
        chk("R2 pin0 untouched", int'(pin_out[0]), 0);
        wr(1, 2, 0);
    endtask

    task automatic t_clock();
        int n;
        wr(0, 0, 40); wr(0, 1, 24); wr(0, 2, 1);
        for (int r = 0; r < 2; r++) begin
            run_len(0, 1'b0, 100, n); chk("R4 low run", n, 5);
            run_len(0, 1'b1, 100, n); chk("R4 high run", n, 3);
        end
    endtask

    task automatic t_carry();
        int n;
        wr(1, 0, 20); wr(1, 1, 12); wr(1, 2, 1);
        for (int r = 0; r < 2; r++) begin
            run_len(1, 1'b0, 100, n); chk("R5 low with carry", n, 3);
            run_len(1, 1'b1, 100, n); chk("R5 high with carry", n, 1);
        end
        wr(1, 2, 0);
    endtask

    task automatic t_step();
        int n, changes;
        logic prev;
        ns_step = 8'd4;
        wr(0, 2, 1);
        run_len(0, 1'b0, 100, n); chk("R6 low at step 4", n, 10);
        run_len(0, 1'b1, 100, n); chk("R6 high at step 4", n, 6);
        ns_tick = 1'b0;
        prev = pin_out[0];
        changes = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pin_out[0] != prev) changes++;
        end
        chk("R6 holds without tick", changes, 0);
        ns_tick = 1'b1;
        ns_step = 8'd8;
    endtask

    task automatic t_update();
        int n;
        wr(0, 0, 40);
        wr(0, 2, 1);
        wr(0, 0, 80);
        run_len(0, 1'b0, 100, n);
        chk("R7 current low unchanged", n + 1, 5);
        run_len(0, 1'b1, 100, n); chk("R7 high", n, 3);
        run_len(0, 1'b0, 100, n); chk("R7 new low used", n, 10);
        wr(0, 0, 40);
    endtask

    task automatic t_idle();
        int n;
        wr(0, 2, 1);
        wait_level(0, 1'b1);
        wr(0, 2, 0);
        run_len(0, 1'b0, 30, n);
        chk("R3 IDLE holds low", n, 30);
        wr(0, 2, 1);
        wait_level(0, 1'b1);
        wr(0, 2, 3);
        run_len(0, 1'b0, 30, n);
        chk("R3 action 3 acts as IDLE", n, 30);
    endtask

    task automatic t_sync();
        int n;
        wr(2, 0, 80); wr(2, 1, 1000); wr(2, 2, 5);
        run_len(2, 1'b0, 40, n); chk("R8 waits for roll-over", n, 40);
        roll();
        run_len(2, 1'b0, 100, n); chk("R8 pulse delay", n, 10);
        run_len(2, 1'b1, 500, n); chk("R8 pulse width", n, 125);
        run_len(2, 1'b0, 300, n); chk("R8 low until next roll-over", n, 300);
    endtask

    task automatic t_rearm();
        int n;
        roll();
        run_len(2, 1'b0, 100, n); chk("R9 delay after roll-over", n, 10);
        repeat (20) @(negedge clk);
        chk("R9 mid pulse", int'(pin_out[2]), 1);
        roll();
        run_len(2, 1'b0, 100, n); chk("R9 re-armed delay", n, 10);
        run_len(2, 1'b1, 500, n); chk("R9 re-armed width", n, 125);
    endtask

    task automatic t_roll_clock();
        int n;
        wr(0, 2, 1);
        sec_roll = 1'b1;
        run_len(0, 1'b0, 100, n); chk("R11 low under roll-over", n, 5);
        run_len(0, 1'b1, 100, n); chk("R11 high under roll-over", n, 3);
        run_len(0, 1'b0, 100, n); chk("R11 second low", n, 5);
        sec_roll = 1'b0;
    endtask

    task automatic t_range();
        int n;
        wr(3, 0, 6); wr(3, 1, 24); wr(3, 2, 1);
        chk("R10 low of 6 flagged", int'(cfg_err[3]), 1);
        run_len(3, 1'b0, 20, n); chk("R10 refused pin idle", n, 20);
        wr(3, 0, 7); wr(3, 2, 1);
        chk("R10 flag sticky", int'(cfg_err[3]), 1);
        run_len(3, 1'b0, 100, n); chk("R10 low of 7 runs", n, 1);
        run_len(3, 1'b1, 100, n); chk("R10 high after low 7", n, 3);
        wr(1, 0, 40); wr(1, 1, 32'h4000_0000); wr(1, 2, 1);
        chk("R10 high too large flagged", int'(cfg_err[1]), 1);
        do_reset();
        chk("R10 reset clears flags", int'(cfg_err), 0);
        wr(0, 0, 32'h3FFF_FFFF); wr(0, 1, 7); wr(0, 2, 1);
        chk("R10 upper limit accepted", int'(cfg_err[0]), 0);
        wr(1, 0, 3); wr(1, 1, 1000); wr(1, 2, 5);
        chk("R10 no check in aligned mode", int'(cfg_err[1]), 0);
        roll();
        run_len(1, 1'b0, 100, n); chk("R8 short delay", n, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        ns_tick = 1'b1;
        t_select();
        t_clock();
        t_carry();
        t_step();
        t_update();
        t_idle();
        t_sync();
        t_rearm();
        t_roll_clock();
        t_range();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule